// File: doc/BRIEF.md
# Multi-channel interprocessor mailbox controller

This block lets processors on one chip hand short messages to each other through memory-mapped registers. It holds a bank of one-way channels. Each channel has its own 64-byte register window, and each can carry up to eight 32-bit data words. A sender first opens the global key lock. It then claims an idle channel by writing a one-hot owner bit and checking that the bit reads back. Next it picks the destination interrupt line or lines, unmasks them, loads the data words and writes its owner bit to the send register. The selected lines of the shared interrupt output vector then go high toward the receiver. The receiver clears its interrupt, and that acknowledges the transfer: automatically in auto-acknowledge mode, or through an explicit mode write otherwise. The owner then releases the channel by writing its bit to the source register once more.

Each channel runs a four-state machine. The states are IDLE, OWNED, SENT and ACKED, and the transitions are:
- CLAIM (IDLE to OWNED): a one-hot source write.
- SEND (OWNED to SENT): a send write that matches the owner.
- AUTO_ACK (SENT to ACKED): in auto mode, an interrupt-clear write that leaves no raised bit.
- MANUAL_ACK (SENT to ACKED): a mode write with bit 7 set.
- RELEASE (ACKED to IDLE): a source write that matches the owner.

The register bus is a single-cycle select/write strobe. Read data is registered and appears one cycle after the read.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset the lock register (byte address 0xA00) reads 1, every channel's mode register reads 0x10 (bit 4 = idle), every mask register reads 0xFFFFFFFF and irq_out is 0.
- R2: Writing 0x1ACCE551 to the lock register unlocks it, and it then reads 0. Writing any other value relocks it, and it then reads 1.
- R3: While locked, writes to the source (0x00), destination (0x04), mode (0x10) and send (0x1C) registers have no effect.
- R4: In IDLE, a source write with exactly one bit set stores that owner bit, which reads back at 0x00, and the mode register's idle bit 4 clears. A source write with zero or several bits set is ignored. A source write with a different bit while the channel is owned is ignored.
- R5: Channel n's window starts at n*0x40. Data word i sits at 0x20+4*i for i in 0..7 and reads back what was written.
- R6: In OWNED, a send write equal to the owner bit moves the channel to SENT and raises the destination bits. Each irq_out line k is the OR over channels of raised bit k AND NOT mask bit k. A send value that differs from the owner is ignored.
- R7: A 1 in a mask register (0x14) suppresses that line for that channel. Writing 1s to interrupt clear (0x18) removes those bits of the channel's contribution, while other channels keep driving a shared line.
- R8: With mode bit 0 = 1 (auto-acknowledge), an interrupt-clear write that leaves no raised bit moves SENT to ACKED, and mode then reads 0x81 (bit 7 = acknowledged).
- R9: With auto mode off, clearing the interrupt leaves the channel in SENT, with mode reading 0x00. A mode write with bit 7 set then moves it to ACKED, with mode reading 0x80.
- R10: In ACKED, a source write equal to the owner bit returns the channel to IDLE and clears the owner, so the source reads 0. The auto bit is kept.
- R11: Destination clear (0x08) clears the written bits of the destination, and destination status (0x0C) reads the current destination.
- R12: Read data appears on bus_rdata one cycle after the read and holds until the next read. Addresses that map to nothing read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_out | output | DW | Interrupt lines toward receivers |

## Verification
Two functions can land on the same edge. The first is an interrupt-clear write that both drops a channel's contribution and, in auto mode, acknowledges the channel. The second is two channels driving the same output line while only one of them is cleared. The bench sends on two channels that target line 5 and clears them one at a time. After each clear it checks that the line stays high while the other channel still drives it, and that the cleared channel's mode already reads acknowledged. A full sweep repeats the whole claim, send, clear and release sequence on every channel, with computed owner and destination bits.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_OWNED = 2'd1,
        CH_SENT  = 2'd2,
        CH_ACKED = 2'd3
    } ch_state_e;

    localparam logic [31:0] LOCK_KEY = 32'h1ACCE551;

    // word index inside a 64-byte channel window
    localparam logic [3:0] W_SRC   = 4'd0;
    localparam logic [3:0] W_DST   = 4'd1;
    localparam logic [3:0] W_DCLR  = 4'd2;
    localparam logic [3:0] W_DSTAT = 4'd3;
    localparam logic [3:0] W_MODE  = 4'd4;
    localparam logic [3:0] W_MASK  = 4'd5;
    localparam logic [3:0] W_ICLR  = 4'd6;
    localparam logic [3:0] W_SEND  = 4'd7;

    localparam int MODE_AUTO_BIT = 0;
    localparam int MODE_IDLE_BIT = 4;
    localparam int MODE_ACK_BIT  = 7;
endpackage

// File: rtl/mbox_lock.sv
module mbox_lock #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          locked_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_o <= 1'b1;
        end else if (wr_en) begin
            locked_o <= (wdata != DW'(mbox_pkg::LOCK_KEY));
        end
    end
endmodule

// File: rtl/mbox_chan.sv
module mbox_chan
    import mbox_pkg::*;
#(
    parameter int DW         = 32,
    parameter int DATA_WORDS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    word,
    input  logic [DW-1:0] wdata,
    input  logic          unlocked,
    output logic [DW-1:0] rd_word,
    output logic [DW-1:0] irq_vec,
    output logic [DW-1:0] src_o
);
    ch_state_e     state_q, state_d;
    logic [DW-1:0] src_q, dst_q, mask_q, raised_q;
    logic          auto_q;
    logic [DW-1:0] data_q [DATA_WORDS];

    logic w_src, w_dst, w_dclr, w_mode, w_mask, w_iclr, w_send, w_data;
    logic [2:0] didx;

    assign w_src  = wr_en && unlocked && (word == W_SRC);
    assign w_dst  = wr_en && unlocked && (word == W_DST);
    assign w_mode = wr_en && unlocked && (word == W_MODE);
    assign w_send = wr_en && unlocked && (word == W_SEND);
    assign w_dclr = wr_en && (word == W_DCLR);
    assign w_mask = wr_en && (word == W_MASK);
    assign w_iclr = wr_en && (word == W_ICLR);
    assign didx   = word[2:0];
    assign w_data = wr_en && word[3] && (int'(didx) < DATA_WORDS);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE:  if (w_src && $onehot(wdata)) state_d = CH_OWNED;      // CLAIM
            CH_OWNED: if (w_send && wdata == src_q) state_d = CH_SENT;      // SEND
            CH_SENT: begin
                if (auto_q && w_iclr && ((raised_q & ~wdata) == '0))
                    state_d = CH_ACKED;                                     // AUTO_ACK
                else if (w_mode && wdata[MODE_ACK_BIT])
                    state_d = CH_ACKED;                                     // MANUAL_ACK
            end
            CH_ACKED: if (w_src && wdata == src_q) state_d = CH_IDLE;       // RELEASE
            default:  state_d = CH_IDLE;
        endcase
    end

    // channel registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q    <= '0;
            dst_q    <= '0;
            mask_q   <= '1;
            raised_q <= '0;
            auto_q   <= 1'b0;
            for (int i = 0; i < DATA_WORDS; i++) data_q[i] <= '0;
        end else begin
            if (state_q == CH_IDLE && state_d == CH_OWNED) src_q <= wdata;
            else if (state_q == CH_ACKED && state_d == CH_IDLE) src_q <= '0;

            if (w_dst && state_q != CH_SENT) dst_q <= wdata;
            else if (w_dclr)                 dst_q <= dst_q & ~wdata;

            if (w_mode && state_q != CH_SENT) auto_q <= wdata[MODE_AUTO_BIT];

            if (w_mask) mask_q <= wdata;

            if (state_q == CH_OWNED && state_d == CH_SENT)      raised_q <= dst_q;
            else if (state_q == CH_SENT && state_d == CH_ACKED) raised_q <= '0;
            else if (w_iclr)                                    raised_q <= raised_q & ~wdata;

            if (w_data) data_q[didx] <= wdata;
        end
    end

    // outputs
    always_comb begin
        rd_word = '0;
        if (word[3]) begin
            if (int'(didx) < DATA_WORDS) rd_word = data_q[didx];
        end else begin
            unique case (word)
                W_SRC:   rd_word = src_q;
                W_DST:   rd_word = dst_q;
                W_DSTAT: rd_word = dst_q;
                W_MODE: begin
                    rd_word[MODE_AUTO_BIT] = auto_q;
                    rd_word[MODE_IDLE_BIT] = (state_q == CH_IDLE);
                    rd_word[MODE_ACK_BIT]  = (state_q == CH_ACKED);
                end
                W_MASK:  rd_word = mask_q;
                W_ICLR:  rd_word = raised_q;
                default: rd_word = '0;
            endcase
        end
    end

    assign irq_vec = raised_q & ~mask_q;
    assign src_o   = src_q;
endmodule

// File: rtl/mbox_irq_or.sv
module mbox_irq_or #(
    parameter int NUM_CH = 32,
    parameter int DW     = 32
) (
    input  logic [NUM_CH-1:0][DW-1:0] vecs,
    output logic [DW-1:0]             irq
);
    always_comb begin
        irq = '0;
        for (int c = 0; c < NUM_CH; c++) irq = irq | vecs[c];
    end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
    parameter int NUM_CH     = 32,
    parameter int DW         = 32,
    parameter int DATA_WORDS = 8,
    parameter int ADDR_W     = 12,
    parameter int LOCK_ADDR  = 'hA00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     irq_out
);
    localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int WIN_END = NUM_CH * 64;

    logic                      lock_q;
    logic                      win_hit, lock_hit;
    logic [CH_W-1:0]           ch_idx;
    logic [3:0]                word;
    logic [NUM_CH-1:0][DW-1:0] chan_rd, chan_irq, chan_src;
    logic [DW-1:0]             rd_mux;

    assign win_hit  = (int'(bus_addr) < WIN_END);
    assign lock_hit = (int'(bus_addr) == LOCK_ADDR);
    assign ch_idx   = bus_addr[6 +: CH_W];
    assign word     = bus_addr[5:2];

    mbox_lock #(.DW(DW)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_sel && bus_wr && lock_hit),
        .wdata    (bus_wdata),
        .locked_o (lock_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        mbox_chan #(.DW(DW), .DATA_WORDS(DATA_WORDS)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_sel && bus_wr && win_hit && (ch_idx == CH_W'(c))),
            .word     (word),
            .wdata    (bus_wdata),
            .unlocked (!lock_q),
            .rd_word  (chan_rd[c]),
            .irq_vec  (chan_irq[c]),
            .src_o    (chan_src[c])
        );
    end

    mbox_irq_or #(.NUM_CH(NUM_CH), .DW(DW)) u_irq (
        .vecs (chan_irq),
        .irq  (irq_out)
    );

    always_comb begin
        rd_mux = '0;
        if (lock_hit)     rd_mux = {{(DW-1){1'b0}}, lock_q};
        else if (win_hit) rd_mux = chan_rd[ch_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  bus_rdata <= '0;
        else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/mbox_ctrl_chk.sv
module mbox_ctrl_chk #(
    parameter int NUM_CH    = 32,
    parameter int DW        = 32,
    parameter int ADDR_W    = 12,
    parameter int LOCK_ADDR = 'hA00
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_sel,
    input logic                      bus_wr,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic [DW-1:0]             bus_wdata,
    input logic [DW-1:0]             bus_rdata,
    input logic [DW-1:0]             irq_out,
    input logic                      locked,
    input logic [NUM_CH-1:0][DW-1:0] chan_src
);
    localparam int WIN_END = NUM_CH * 64;

    p_key_unlocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && int'(bus_addr) == LOCK_ADDR && bus_wdata == DW'(mbox_pkg::LOCK_KEY))
        |=> !locked);

    p_bad_key_relocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && int'(bus_addr) == LOCK_ADDR && bus_wdata != DW'(mbox_pkg::LOCK_KEY))
        |=> locked);

    p_locked_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && locked && int'(bus_addr) < WIN_END && bus_addr[5:2] == 4'd0)
        |=> $stable(chan_src));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_own
        p_owner_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(chan_src[c]));
    end

    p_irq_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != $past(irq_out)) |-> $past(bus_sel && bus_wr));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind mbox_ctrl mbox_ctrl_chk #(
    .NUM_CH(NUM_CH), .DW(DW), .ADDR_W(ADDR_W), .LOCK_ADDR(LOCK_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .locked    (lock_q),
    .chan_src  (chan_src)
);

// File: tb/sim_mbox_ctrl.sv
module sim_mbox_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_out;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 1'b0;

    mbox_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] ca(int ch, int off);
        return 12'(ch * 64 + off);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rchk(string req, logic [11:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] own, dst, dw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", irq_out, 32'h0);
        rchk("R1 lock", 12'hA00, 32'h1);
        rchk("R1 mode", ca(5, 'h10), 32'h10);
        rchk("R1 mask", ca(5, 'h14), 32'hFFFFFFFF);

        // R3 locked writes ignored
        wr(ca(5, 'h00), 32'h1);
        rchk("R3 src locked", ca(5, 'h00), 32'h0);
        wr(ca(5, 'h10), 32'h1);
        rchk("R3 mode locked", ca(5, 'h10), 32'h10);
        wr(ca(5, 'h04), 32'h1);
        rchk("R3 dst locked", ca(5, 'h0C), 32'h0);

        // R2 unlock
        wr(12'hA00, 32'h1ACCE551);
        rchk("R2 unlock", 12'hA00, 32'h0);

        // sweep: every channel through claim/send/ack/release
        for (int ch = 0; ch < NCH; ch++) begin
            own = 32'h1 << (ch % 32);
            dst = 32'h1 << ((ch + 7) % 32);
            dw  = 32'hA000_0000 | (ch << 8) | (ch % 8);
            wr(ca(ch, 'h00), own);
            rchk("R4 claim", ca(ch, 'h00), own);
            rchk("R4 owned mode", ca(ch, 'h10), 32'h0);
            wr(ca(ch, 'h04), dst);
            rchk("R11 dstat", ca(ch, 'h0C), dst);
            wr(ca(ch, 'h14), ~dst);
            wr(ca(ch, 'h10), 32'h1);
            wr(ca(ch, 'h20 + 4 * (ch % 8)), dw);
            rchk("R5 data", ca(ch, 'h20 + 4 * (ch % 8)), dw);
            wr(ca(ch, 'h1C), own);
            check("R6 irq raised", irq_out, dst);
            wr(ca(ch, 'h18), dst);
            check("R7 irq cleared", irq_out, 32'h0);
            rchk("R8 auto ack", ca(ch, 'h10), 32'h81);
            wr(ca(ch, 'h00), own);
            rchk("R10 release mode", ca(ch, 'h10), 32'h11);
            rchk("R10 release src", ca(ch, 'h00), 32'h0);
        end

        // R7 shared line from two channels
        wr(ca(0, 'h00), 32'h1);
        wr(ca(1, 'h00), 32'h2);
        wr(ca(0, 'h04), 32'h20);
        wr(ca(1, 'h04), 32'h20);
        wr(ca(0, 'h14), ~32'h20);
        wr(ca(1, 'h14), ~32'h20);
        wr(ca(0, 'h1C), 32'h1);
        wr(ca(1, 'h1C), 32'h2);
        check("R6 two senders", irq_out, 32'h20);
        wr(ca(0, 'h14), 32'hFFFFFFFF);
        check("R7 one masked", irq_out, 32'h20);
        wr(ca(0, 'h18), 32'h20);
        check("R7 other holds line", irq_out, 32'h20);
        rchk("R8 ack with shared line", ca(0, 'h10), 32'h81);
        wr(ca(1, 'h14), 32'hFFFFFFFF);
        check("R7 mask suppresses", irq_out, 32'h0);
        wr(ca(1, 'h14), ~32'h20);
        check("R7 unmask restores", irq_out, 32'h20);
        wr(ca(1, 'h18), 32'h20);
        check("R7 both cleared", irq_out, 32'h0);

        // R9 manual acknowledge on channel 2
        wr(ca(2, 'h00), 32'h4);
        wr(ca(2, 'h10), 32'h0);
        wr(ca(2, 'h04), 32'h200);
        wr(ca(2, 'h14), 32'h0);
        wr(ca(2, 'h1C), 32'h4);
        check("R6 manual send", irq_out, 32'h200);
        wr(ca(2, 'h18), 32'h200);
        check("R9 irq clear", irq_out, 32'h0);
        rchk("R9 still sent", ca(2, 'h10), 32'h00);
        wr(ca(2, 'h10), 32'h80);
        rchk("R9 manual ack", ca(2, 'h10), 32'h80);
        wr(ca(2, 'h00), 32'h4);
        rchk("R10 manual release", ca(2, 'h10), 32'h10);

        // R4 bad claims and R6 mismatched send on channel 3
        wr(ca(3, 'h00), 32'h3);
        rchk("R4 multi-bit ignored", ca(3, 'h00), 32'h0);
        rchk("R4 still idle", ca(3, 'h10), 32'h11);
        wr(ca(3, 'h00), 32'h2);
        wr(ca(3, 'h00), 32'h4);
        rchk("R4 contender ignored", ca(3, 'h00), 32'h2);
        wr(ca(3, 'h04), 32'h800);
        wr(ca(3, 'h14), 32'h0);
        wr(ca(3, 'h1C), 32'h4);
        check("R6 wrong send", irq_out, 32'h0);
        rchk("R6 still owned", ca(3, 'h10), 32'h01);
        wr(ca(3, 'h08), 32'h800);
        rchk("R11 dclr", ca(3, 'h0C), 32'h0);

        // R12 unmapped address
        rchk("R12 unmapped", 12'h900, 32'h0);

        // R2 relock, R3 then ignored
        wr(12'hA00, 32'h0);
        rchk("R2 relock", 12'hA00, 32'h1);
        wr(ca(3, 'h04), 32'h1);
        rchk("R3 dst relocked", ca(3, 'h0C), 32'h0);
        wr(ca(3, 'h1C), 32'h2);
        check("R3 send relocked", irq_out, 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule